// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the 64-byte standard configuration header of a single endpoint function. A configuration access port presents one request at a time. Each request carries a byte offset, an access size of one, two or four bytes, write data and a write flag. Exactly one cycle later the block answers with read data, an error flag and a one-cycle completion pulse.

The header holds several kinds of register:
- Identification and other fixed fields. These read back values set by parameters, and writes to them are dropped.
- Command, cache line size, latency timer and interrupt line. These are writable, and their reset values come from parameters.
- Six base address registers (BARs). Each has a parameter size that is zero or a power of two, and its low type bits survive every write.
- The expansion ROM base register.

Software discovers how much address space a BAR decodes by writing all ones to it and reading back a size mask. The ROM register uses its own probe pattern. Whenever a BAR receives a real, nonzero address, the block pulses a range-change output so that the address decoders around it can reload.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: Reset loads the command, cache line size, latency timer, interrupt line and ROM base from their parameters. Reset also clears the address bits of every BAR, leaving only its 4-bit type parameter, and keeps `rsp_valid` and `bar_range_change` low.
- R2: Each accepted request (`acc_valid` high for one cycle) produces exactly one `rsp_valid` pulse on the following cycle. No response appears without a request.
- R3: A request whose size is not 1, 2 or 4, or whose offset is 0x40 or above, is answered with `rsp_err`=1 and `rsp_rdata`=0, and it changes no register.
- R4: A read returns the header bytes little-endian, starting at the offset: byte k of `rsp_rdata` is header byte offset+k for k < size, and 0 otherwise. Header bytes above 0x3F read as 0. Writes answer with `rsp_rdata`=0. Offset 0x00 holds {DEVICE_ID, VENDOR_ID}, 0x08 holds {CLASS_CODE, REV_ID} and 0x3C holds {MAX_LAT, MIN_GNT, INT_PIN, interrupt line}.
- R5: A 4-byte write of 0xFFFFFFFF to BAR n (offset 0x10 + 4n) makes it read as ~(size-1) in its upper bits, with its preserved low bits unchanged. A BAR of size 0 then reads as its type bits only.
- R6: Any other 4-byte BAR write stores the written upper bits and keeps the old low bits. Two low bits are kept when the old bit 0 is 1 (I/O BAR), and four otherwise (memory BAR).
- R7: A 4-byte write of 0xFFFFFFFE to offset 0x30 makes the ROM register read 0xFFFFFFFF. Any other 4-byte write there is stored as written.
- R8: A 2- or 4-byte write to offset 0x04 loads the command register from `acc_wdata`[15:0]. The status half (offset 0x06, parameter STATUS_VAL) is left unchanged.
- R9: 1-byte writes to 0x0C (cache line size), 0x0D (latency timer) and 0x3C (interrupt line) each change only the addressed byte.
- R10: 1-byte writes to the read-only bytes are answered without error and change nothing. These bytes include the revision ID (0x08), class code (0x09–0x0B), interrupt pin (0x3D), minimum grant (0x3E) and maximum latency (0x3F).
- R11: `bar_range_change` pulses together with `rsp_valid` when a BAR write that is not the all-ones probe has a nonzero value after its preserved low bits are masked off. It stays low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| acc_wdata | input | 32 | Write data, little-endian from the offset |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected (bad size or offset) |
| rsp_rdata | output | 32 | Read data |
| bar_range_change | output | 1 | A BAR was given a new nonzero address |

## Verification
The checker watches every cycle for the following:
- Each request is followed by exactly one completion.
- An error response carries zero data.
- Out-of-range offsets and illegal sizes always produce an error.
- A range-change pulse appears only inside the completion of a write.

The bench's scenarios cover what can only be seen through read-back:
- Probe masks for I/O, memory and zero-size BARs.
- The preservation of the type bits.
- The ROM probe pattern.
- Byte isolation between neighbouring registers.
- Writes to read-only bytes that have no effect.
- Errored writes that leave the command register untouched.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int HDR_BYTES  = 64;
    localparam int HDR_DWORDS = HDR_BYTES / 4;
    localparam int NUM_BARS   = 6;

    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_CACHE = 8'h0C;
    localparam logic [7:0] OFS_LAT   = 8'h0D;
    localparam logic [7:0] OFS_BAR0  = 8'h10;
    localparam logic [7:0] OFS_ROM   = 8'h30;
    localparam logic [7:0] OFS_INTLN = 8'h3C;

    localparam logic [31:0] BAR_PROBE = 32'hFFFF_FFFF;
    localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic [7:0]  offset;
        logic [2:0]  size;
        logic [31:0] wdata;
    } cfg_req_t;

    typedef struct packed {
        logic [31:0] value;
        logic        announce;
    } bar_next_t;

    function automatic logic size_legal(input logic [2:0] s);
        return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    endfunction

    // Low bits that survive a write: 2 for I/O decoders, 4 for memory.
    function automatic logic [31:0] keep_mask(input logic [31:0] old);
        return old[0] ? 32'h0000_0003 : 32'h0000_000F;
    endfunction

    function automatic bar_next_t bar_update(input logic [31:0] old,
                                             input logic [31:0] wdata,
                                             input logic [31:0] size);
        bar_next_t   r;
        logic [31:0] m;
        logic [31:0] upper;
        m = keep_mask(old);
        if (wdata == BAR_PROBE) begin
            upper      = ~(size - 32'd1);
            r.announce = 1'b0;
        end else begin
            upper      = wdata & ~m;
            r.announce = (upper != 32'd0);
        end
        r.value = (upper & ~m) | (old & m);
        return r;
    endfunction

endpackage

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] SIZE = 32'h0000_1000,
    parameter logic [3:0]  TYPE = 4'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] value,
    output logic        announce
);

    localparam logic [31:0] RESET_VAL = {28'd0, TYPE};

    bar_next_t nxt;

    always_comb nxt = bar_update(value, wdata, SIZE);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= RESET_VAL;
        end else if (wr_en) begin
            value <= nxt.value;
        end
    end

    assign announce = wr_en & nxt.announce;

endmodule

// File: rtl/cfg_rom_reg.sv
module cfg_rom_reg
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] INIT = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= INIT;
        end else if (wr_en) begin
            value <= (wdata == ROM_PROBE) ? 32'hFFFF_FFFF : wdata;
        end
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_hdr_pkg::*;
(
    input  logic [HDR_BYTES*8-1:0] image,
    input  logic [7:0]             offset,
    input  logic [2:0]             size,
    output logic [31:0]            rdata
);

    logic [7:0] addr [4];

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign addr[b] = offset + 8'(b);
        always_comb begin
            if ((3'(b) < size) && (addr[b] < 8'(HDR_BYTES)))
                rdata[8*b +: 8] = image[8*addr[b][5:0] +: 8];
            else
                rdata[8*b +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h5A17,
    parameter logic [15:0] DEVICE_ID  = 16'hC3E9,
    parameter logic [7:0]  REV_ID     = 8'h04,
    parameter logic [23:0] CLASS_CODE = 24'h028000,
    parameter logic [7:0]  HDR_TYPE   = 8'h00,
    parameter logic [15:0] STATUS_VAL = 16'h0200,
    parameter logic [15:0] SUBSYS_VID = 16'h5A17,
    parameter logic [15:0] SUBSYS_ID  = 16'h0042,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter logic [7:0]  MIN_GNT    = 8'h10,
    parameter logic [7:0]  MAX_LAT    = 8'h20,
    parameter logic [15:0] CMD_INIT   = 16'h0000,
    parameter logic [7:0]  CACHE_INIT = 8'h00,
    parameter logic [7:0]  LAT_INIT   = 8'h00,
    parameter logic [7:0]  INTLN_INIT = 8'h0B,
    parameter logic [31:0] ROM_INIT   = 32'h0000_0000,
    // Sizes and type nibbles, BAR0 in the lowest slice.
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE = {32'h0000_0000, 32'h0000_0020,
                                                  32'h0010_0000, 32'h0000_0000,
                                                  32'h0000_0100, 32'h0000_1000},
    parameter logic [NUM_BARS*4-1:0]  BAR_TYPE = {4'h0, 4'h1, 4'h8, 4'h0, 4'h1, 4'h0}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [7:0]  acc_offset,
    input  logic [2:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        bar_range_change
);

    cfg_req_t req;
    logic     req_err;
    logic     do_write;
    logic     wr_word;
    logic     wr_byte;

    assign req      = '{valid: acc_valid, write: acc_write, offset: acc_offset,
                        size: acc_size, wdata: acc_wdata};
    assign req_err  = !size_legal(req.size) || (req.offset >= 8'(HDR_BYTES));
    assign do_write = req.valid && req.write && !req_err;
    assign wr_word  = do_write && (req.size == 3'd4);
    assign wr_byte  = do_write && (req.size == 3'd1);

    // Writable scalar registers
    logic [15:0] cmd_q;
    logic [7:0]  cache_q;
    logic [7:0]  lat_q;
    logic [7:0]  intln_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_INIT;
            cache_q <= CACHE_INIT;
            lat_q   <= LAT_INIT;
            intln_q <= INTLN_INIT;
        end else begin
            if (do_write && (req.size != 3'd1) && (req.offset == OFS_CMD))
                cmd_q <= req.wdata[15:0];
            if (wr_byte && (req.offset == OFS_CACHE)) cache_q <= req.wdata[7:0];
            if (wr_byte && (req.offset == OFS_LAT))   lat_q   <= req.wdata[7:0];
            if (wr_byte && (req.offset == OFS_INTLN)) intln_q <= req.wdata[7:0];
        end
    end

    // Base address registers
    logic [31:0]         bar_val [NUM_BARS];
    logic [NUM_BARS-1:0] bar_ann;

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        cfg_bar_reg #(
            .SIZE (BAR_SIZE[i*32 +: 32]),
            .TYPE (BAR_TYPE[i*4 +: 4])
        ) i_bar (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_word && (req.offset == OFS_BAR0 + 8'(4*i))),
            .wdata    (req.wdata),
            .value    (bar_val[i]),
            .announce (bar_ann[i])
        );
    end

    logic [31:0] rom_val;

    cfg_rom_reg #(.INIT(ROM_INIT)) i_rom (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_word && (req.offset == OFS_ROM)),
        .wdata (req.wdata),
        .value (rom_val)
    );

    // Header image, one dword per slot
    logic [HDR_DWORDS-1:0][31:0] hdr;

    always_comb begin
        hdr     = '0;
        hdr[0]  = {DEVICE_ID, VENDOR_ID};
        hdr[1]  = {STATUS_VAL, cmd_q};
        hdr[2]  = {CLASS_CODE, REV_ID};
        hdr[3]  = {8'h00, HDR_TYPE, lat_q, cache_q};
        for (int i = 0; i < NUM_BARS; i++) hdr[4 + i] = bar_val[i];
        hdr[11] = {SUBSYS_ID, SUBSYS_VID};
        hdr[12] = rom_val;
        hdr[15] = {MAX_LAT, MIN_GNT, INT_PIN, intln_q};
    end

    logic [31:0] rd_word;

    cfg_read_mux i_rdmux (
        .image  (hdr),
        .offset (req.offset),
        .size   (req.size),
        .rdata  (rd_word)
    );

    // Response stage
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid        <= 1'b0;
            rsp_err          <= 1'b0;
            rsp_rdata        <= '0;
            bar_range_change <= 1'b0;
        end else begin
            rsp_valid        <= req.valid;
            rsp_err          <= req.valid && req_err;
            rsp_rdata        <= (req.valid && !req.write && !req_err) ? rd_word : 32'd0;
            bar_range_change <= |bar_ann;
        end
    end

endmodule

// File: rtl/cfg_hdr_checker.sv
module cfg_hdr_checker (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [7:0]  acc_offset,
    input logic [2:0]  acc_size,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        bar_range_change
);

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);

    a_r3_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    a_r3_offset_rejected: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_offset >= 8'h40) |=> rsp_err);

    a_r3_size_rejected: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_size != 3'd1 && acc_size != 3'd2 && acc_size != 3'd4)
        |=> rsp_err);

    a_r11_range_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> !bar_range_change);

    a_r11_range_with_rsp: assert property (@(posedge clk) disable iff (rst)
        bar_range_change |-> (rsp_valid && !rsp_err));

endmodule

bind cfg_hdr_regfile cfg_hdr_checker i_chk (
    .clk              (clk),
    .rst              (rst),
    .acc_valid        (acc_valid),
    .acc_write        (acc_write),
    .acc_offset       (acc_offset),
    .acc_size         (acc_size),
    .rsp_valid        (rsp_valid),
    .rsp_err          (rsp_err),
    .rsp_rdata        (rsp_rdata),
    .bar_range_change (bar_range_change)
);

// File: tb/test_cfg_hdr_regfile.sv
`timescale 1ns/1ps
module test_cfg_hdr_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_offset = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        bar_range_change;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        q_err  [$];
    logic [31:0] q_data [$];
    logic        q_rc   [$];
    string       q_tag  [$];

    always #4 clk = ~clk;

    cfg_hdr_regfile i_cfg_hdr_regfile (
        .clk              (clk),
        .rst              (rst),
        .acc_valid        (acc_valid),
        .acc_write        (acc_write),
        .acc_offset       (acc_offset),
        .acc_size         (acc_size),
        .acc_wdata        (acc_wdata),
        .rsp_valid        (rsp_valid),
        .rsp_err          (rsp_err),
        .rsp_rdata        (rsp_rdata),
        .bar_range_change (bar_range_change)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [7:0] ofs, input logic [2:0] sz,
                       input logic [31:0] wd, input logic e_err, input logic [31:0] e_data,
                       input logic e_rc, input string tag);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = ofs;
        acc_size   = sz;
        acc_wdata  = wd;
        q_err.push_back(e_err);
        q_data.push_back(e_data);
        q_rc.push_back(e_rc);
        q_tag.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ofs, input logic [2:0] sz,
                      input logic [31:0] e_data, input string tag);
        acc(1'b0, ofs, sz, 32'd0, 1'b0, e_data, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] ofs, input logic [2:0] sz,
                      input logic [31:0] wd, input logic e_rc, input string tag);
        acc(1'b1, ofs, sz, wd, 1'b0, 32'd0, e_rc, tag);
    endtask

    // Monitor: pop expected item on each completion
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (q_tag.size() == 0) begin
                    check("R2 unexpected response", 32'd1, 32'd0);
                end else begin
                    automatic string t = q_tag.pop_front();
                    check({t, " err"},   {31'd0, rsp_err},          {31'd0, q_err.pop_front()});
                    check({t, " data"},  rsp_rdata,                 q_data.pop_front());
                    check({t, " range"}, {31'd0, bar_range_change}, {31'd0, q_rc.pop_front()});
                end
            end else if (bar_range_change) begin
                check("R11 range pulse without response", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 range after reset", {31'd0, bar_range_change}, 32'd0);

        // R1 reset values
        rd(8'h04, 3'd4, 32'h0200_0000, "R1 command/status");
        rd(8'h14, 3'd4, 32'h0000_0001, "R1 BAR1 type only");
        rd(8'h1C, 3'd4, 32'h0000_0008, "R1 BAR3 type only");
        rd(8'h30, 3'd4, 32'h0000_0000, "R1 ROM init");
        rd(8'h0C, 3'd4, 32'h0000_0000, "R1 cache/latency");

        // R4 identification and byte lanes
        rd(8'h00, 3'd4, 32'hC3E9_5A17, "R4 ids dword");
        rd(8'h02, 3'd2, 32'h0000_C3E9, "R4 device half");
        rd(8'h0A, 3'd1, 32'h0000_0080, "R4 class byte");
        rd(8'h08, 3'd4, 32'h0280_0004, "R4 class/rev");
        rd(8'h3C, 3'd4, 32'h2010_010B, "R4 interrupt dword");
        rd(8'h3E, 3'd4, 32'h0000_2010, "R4 tail past header");
        rd(8'h2C, 3'd4, 32'h0042_5A17, "R4 subsystem");

        // R3 errors
        acc(1'b0, 8'h40, 3'd4, 32'd0, 1'b1, 32'd0, 1'b0, "R3 offset 0x40");
        acc(1'b0, 8'h00, 3'd3, 32'd0, 1'b1, 32'd0, 1'b0, "R3 size 3");
        acc(1'b1, 8'h04, 3'd0, 32'hFFFF_FFFF, 1'b1, 32'd0, 1'b0, "R3 write size 0");
        acc(1'b1, 8'h10, 3'd3, 32'hFFFF_FFFF, 1'b1, 32'd0, 1'b0, "R3 BAR write size 3");
        rd(8'h04, 3'd4, 32'h0200_0000, "R3 command untouched");
        rd(8'h10, 3'd4, 32'h0000_0000, "R3 BAR0 untouched");

        // R5 probing
        wr(8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 BAR0 probe");
        rd(8'h10, 3'd4, 32'hFFFF_F000, "R5 BAR0 mask");
        wr(8'h14, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 BAR1 probe");
        rd(8'h14, 3'd4, 32'hFFFF_FF01, "R5 BAR1 io mask");
        wr(8'h18, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 BAR2 probe");
        rd(8'h18, 3'd4, 32'h0000_0000, "R5 BAR2 size zero");
        wr(8'h1C, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 BAR3 probe");
        rd(8'h1C, 3'd4, 32'hFFF0_0008, "R5 BAR3 prefetch mask");

        // R6 / R11 address writes
        wr(8'h10, 3'd4, 32'h1234_5678, 1'b1, "R11 BAR0 addr write");
        rd(8'h10, 3'd4, 32'h1234_5670, "R6 BAR0 low nibble kept");
        wr(8'h14, 3'd4, 32'hABCD_EF02, 1'b1, "R11 BAR1 addr write");
        rd(8'h14, 3'd4, 32'hABCD_EF01, "R6 BAR1 low pair kept");
        wr(8'h10, 3'd4, 32'h0000_000F, 1'b0, "R11 BAR0 zero addr");
        rd(8'h10, 3'd4, 32'h0000_0000, "R6 BAR0 cleared");
        wr(8'h1C, 3'd4, 32'h0000_0000, 1'b0, "R11 BAR3 zero");
        rd(8'h1C, 3'd4, 32'h0000_0008, "R6 BAR3 type kept");
        wr(8'h20, 3'd4, 32'h0000_C001, 1'b1, "R11 BAR4 addr write");
        rd(8'h20, 3'd4, 32'h0000_C001, "R6 BAR4 io");

        // R7 ROM
        wr(8'h30, 3'd4, 32'hFFFF_FFFE, 1'b0, "R7 ROM probe");
        rd(8'h30, 3'd4, 32'hFFFF_FFFF, "R7 ROM probe readback");
        wr(8'h30, 3'd4, 32'h1234_0001, 1'b0, "R7 ROM write");
        rd(8'h30, 3'd4, 32'h1234_0001, "R7 ROM stored");

        // R8 command
        wr(8'h04, 3'd4, 32'hFFFF_0007, 1'b0, "R8 cmd word write");
        rd(8'h04, 3'd4, 32'h0200_0007, "R8 status kept");
        wr(8'h04, 3'd2, 32'h0000_0146, 1'b0, "R8 cmd half write");
        rd(8'h04, 3'd4, 32'h0200_0146, "R8 cmd half readback");

        // R9 byte isolation
        wr(8'h0C, 3'd1, 32'hFFFF_FF40, 1'b0, "R9 cache byte");
        rd(8'h0C, 3'd4, 32'h0000_0040, "R9 cache only");
        wr(8'h0D, 3'd1, 32'h0000_0080, 1'b0, "R9 latency byte");
        rd(8'h0C, 3'd4, 32'h0000_8040, "R9 latency only");
        wr(8'h3C, 3'd1, 32'h0000_0055, 1'b0, "R9 int line byte");
        rd(8'h3C, 3'd4, 32'h2010_0155, "R9 int line only");

        // R10 read-only bytes
        wr(8'h3D, 3'd1, 32'h0000_00FF, 1'b0, "R10 int pin write");
        wr(8'h3E, 3'd1, 32'h0000_00FF, 1'b0, "R10 min gnt write");
        wr(8'h3F, 3'd1, 32'h0000_00FF, 1'b0, "R10 max lat write");
        rd(8'h3C, 3'd4, 32'h2010_0155, "R10 interrupt dword unchanged");
        wr(8'h08, 3'd1, 32'h0000_00FF, 1'b0, "R10 rev write");
        wr(8'h09, 3'd1, 32'h0000_00FF, 1'b0, "R10 class write");
        rd(8'h08, 3'd4, 32'h0280_0004, "R10 class/rev unchanged");

        repeat (3) @(negedge clk);
        check("R2 all responses seen", q_tag.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule